// File: doc/BRIEF.md
# Record Segmentation and Status Tracker

This block follows one data transfer that is cut into records of equal length. Before a transfer, the host loads three values through a small write port: the length of one record in bytes, the number of records, and the number of leading records whose output is thrown away. A start strobe begins the transfer. A mode bit on the same strobe picks normal output or output-discard.

While the transfer runs, the block counts the byte strobes on the input side and on the output side. Strobes marked as padding are not counted. At the last byte of each record the block pulses an end-of-record flag and reduces the remaining record count. It also keeps a small status vector. That vector carries the busy, done, expansion, output-counter overflow, illegal-length, any-error and output-disabled flags. A done interrupt line follows the done flag unless it is masked.

The counter width is a parameter. It is 32 bits by default, which allows records of up to 4 GB.

Top module: `rec_seg_tracker`

## Requirements
- R1: After reset, all seven status bits are 0, both byte counters are 0, the remaining record count is 0 and the end-of-record flag is 0. The status bit positions are: 0 busy, 1 done, 2 expand, 3 overflow error, 4 length error, 5 any error, 6 output disabled.
- R2: A configuration write takes effect only while busy is 0. cfgSel selects the register: 0 is the record length, 1 is the record count, 2 is the discard count. A write made while busy is ignored, so the records of the running transfer keep the length they started with.
- R3: A start accepted while idle with a legal length does the following in the next cycle. It sets busy. It clears done, any error, length error and overflow error. It sets both byte counters to 0. It sets the remaining record count to the programmed count, where a count of 0 is taken as 1.
- R4: A record length is illegal when it is 0, or when it is 0x22 or less while the effective record count is greater than 1. An illegal length at start sets the length error and any error bits, and busy stays 0.
- R5: While busy, each input strobe with inPad low adds one to inCount. Each output strobe with outPad low adds one to outCount. A strobe with its pad bit high changes neither counter.
- R6: The input byte that completes a record raises eor for exactly the following cycle. If more than one record remains, recLeft drops by one and a new record begins. After the last record, recLeft stays at 1 and further input bytes are not counted.
- R7: An output byte marked outLast completes the transfer only when the input of the last record is finished. Completion clears busy and sets done. doneIrq equals done while doneMask is low, and is 0 while doneMask is high. An outLast that comes earlier has no effect on done.
- R8: The expand bit is 1 exactly while outCount is greater than inCount. It follows the counts in both directions during a transfer.
- R9: An output byte that arrives when outCount is at its maximum value leaves outCount unchanged. It sets the overflow error and any error bits and clears busy.
- R10: A start with outDisMode high and a nonzero discard count sets output disabled. While output disabled is 1, output strobes are dropped. Output disabled clears at the end of the record that uses up the discard count, and later output bytes are counted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 length, 1 record count, 2 discard count |
| cfgData | input | CNT_W | Configuration write data |
| start | input | 1 | Start a transfer (ignored while busy) |
| outDisMode | input | 1 | Start in output-discard mode |
| inByte | input | 1 | Input-side byte strobe |
| inPad | input | 1 | Marks the input strobe as padding |
| outByte | input | 1 | Output-side byte strobe |
| outPad | input | 1 | Marks the output strobe as padding |
| outLast | input | 1 | Marks the output byte as the final one of the transfer |
| doneMask | input | 1 | Masks the done interrupt |
| inCount | output | CNT_W | Input bytes counted in this transfer |
| outCount | output | CNT_W | Output bytes counted in this transfer |
| recLeft | output | CNT_W | Records remaining, including the current one |
| eor | output | 1 | One-cycle end-of-record pulse |
| status | output | 7 | Status vector (bit positions in R1) |
| doneIrq | output | 1 | Done interrupt |

## Verification
The hardest state to reach from the ports is the output-counter overflow. At 32 bits it would take billions of output strobes. The bench therefore builds the block with an 8-bit counter, pushes the output count to its ceiling while no input arrives, and then sends one more byte. The bench also moves the expansion flag both ways. It checks that a length written in the middle of a transfer does not move the record boundary.

// File: rtl/rec_trk_pkg.sv
package rec_trk_pkg;
  localparam int ST_BUSY   = 0;
  localparam int ST_DONE   = 1;
  localparam int ST_EXPAND = 2;
  localparam int ST_OVF    = 3;
  localparam int ST_LENERR = 4;
  localparam int ST_ANYERR = 5;
  localparam int ST_OUTDIS = 6;
  localparam int ST_W      = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic cntIn;
    logic cntOut;
    logic lenWe;
    logic cntWe;
  } dpCtl_t;
endpackage

// File: rtl/rec_trk_dp.sv
module rec_trk_dp
  import rec_trk_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int MIN_LEN = 34
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [CNT_W-1:0] cfgData,
  output logic [CNT_W-1:0] inCount,
  output logic [CNT_W-1:0] outCount,
  output logic [CNT_W-1:0] recLeft,
  output logic             eor,
  output logic             expand,
  output logic             lenBad,
  output logic             lenIsOne,
  output logic             lenZero,
  output logic             recIsOne,
  output logic             outFull
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_LEN);

  logic [CNT_W-1:0] lenReg, cntReg, lenLeft, effCnt;

  always_comb begin
    effCnt   = (cntReg == '0) ? ONE : cntReg;
    lenBad   = (lenReg == '0) || ((effCnt > ONE) && (lenReg <= FLOOR));
    lenIsOne = (lenLeft == ONE);
    lenZero  = (lenLeft == '0);
    recIsOne = (recLeft == ONE);
    outFull  = (outCount == '1);
    expand   = (outCount > inCount);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg   <= '0;
      cntReg   <= '0;
      lenLeft  <= '0;
      recLeft  <= '0;
      inCount  <= '0;
      outCount <= '0;
      eor      <= 1'b0;
    end else begin
      if (ctl.lenWe) lenReg <= cfgData;
      if (ctl.cntWe) cntReg <= cfgData;
      eor <= ctl.cntIn && lenIsOne;
      if (ctl.load) begin
        lenLeft  <= lenReg;
        recLeft  <= effCnt;
        inCount  <= '0;
        outCount <= '0;
      end else begin
        if (ctl.cntIn) begin
          inCount <= inCount + ONE;
          if (lenIsOne && (recLeft > ONE)) begin
            lenLeft <= lenReg;
            recLeft <= recLeft - ONE;
          end else begin
            lenLeft <= lenLeft - ONE;
          end
        end
        if (ctl.cntOut) outCount <= outCount + ONE;
      end
    end
  end

  // R5
  out_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> outCount >= $past(outCount));

  // R6
  rec_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntIn && !ctl.load |=> recLeft != '0);
endmodule

// File: rtl/rec_trk_ctrl.sv
module rec_trk_ctrl
  import rec_trk_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [CNT_W-1:0] cfgData,
  input  logic             start,
  input  logic             outDisMode,
  input  logic             inByte,
  input  logic             inPad,
  input  logic             outByte,
  input  logic             outPad,
  input  logic             outLast,
  input  logic             lenBad,
  input  logic             lenIsOne,
  input  logic             lenZero,
  input  logic             recIsOne,
  input  logic             outFull,
  output dpCtl_t           ctl,
  output logic             busy,
  output logic             done,
  output logic             ovfErr,
  output logic             lenErr,
  output logic             anyErr,
  output logic             outDis
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] ddcReg, discLeft;
  logic accept, outHit, finish, ovfHit, recEnd;

  always_comb begin
    accept     = start && !busy;
    ctl.load   = accept && !lenBad;
    ctl.lenWe  = cfgWe && !busy && (cfgSel == 2'd0);
    ctl.cntWe  = cfgWe && !busy && (cfgSel == 2'd1);
    ctl.cntIn  = busy && inByte && !inPad && !lenZero;
    outHit     = busy && outByte && !outPad && !outDis;
    ctl.cntOut = outHit && !outFull;
    ovfHit     = outHit && outFull;
    finish     = ctl.cntOut && outLast && lenZero && recIsOne;
    recEnd     = ctl.cntIn && lenIsOne;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ddcReg   <= '0;
      discLeft <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      ovfErr   <= 1'b0;
      lenErr   <= 1'b0;
      anyErr   <= 1'b0;
      outDis   <= 1'b0;
    end else begin
      if (cfgWe && !busy && (cfgSel == 2'd2)) ddcReg <= cfgData;
      if (accept) begin
        if (lenBad) begin
          lenErr <= 1'b1;
          anyErr <= 1'b1;
        end else begin
          busy     <= 1'b1;
          done     <= 1'b0;
          ovfErr   <= 1'b0;
          lenErr   <= 1'b0;
          anyErr   <= 1'b0;
          discLeft <= ddcReg;
          outDis   <= outDisMode && (ddcReg != '0);
        end
      end else begin
        if (finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        if (ovfHit) begin
          ovfErr <= 1'b1;
          anyErr <= 1'b1;
          busy   <= 1'b0;
        end
        if (recEnd && outDis) begin
          discLeft <= discLeft - ONE;
          if (discLeft == ONE) outDis <= 1'b0;
        end
      end
    end
  end

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  // R4
  lenerr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |-> !busy);

  // R10
  outdis_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outDis) |-> busy);
endmodule

// File: rtl/rec_seg_tracker.sv
module rec_seg_tracker
  import rec_trk_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int MIN_LEN = 34
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [CNT_W-1:0] cfgData,
  input  logic             start,
  input  logic             outDisMode,
  input  logic             inByte,
  input  logic             inPad,
  input  logic             outByte,
  input  logic             outPad,
  input  logic             outLast,
  input  logic             doneMask,
  output logic [CNT_W-1:0] inCount,
  output logic [CNT_W-1:0] outCount,
  output logic [CNT_W-1:0] recLeft,
  output logic             eor,
  output logic [ST_W-1:0]  status,
  output logic             doneIrq
);
  dpCtl_t ctl;
  logic lenBad, lenIsOne, lenZero, recIsOne, outFull, expand;
  logic busy, done, ovfErr, lenErr, anyErr, outDis;

  rec_trk_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .start(start), .outDisMode(outDisMode), .inByte(inByte), .inPad(inPad),
    .outByte(outByte), .outPad(outPad), .outLast(outLast),
    .lenBad(lenBad), .lenIsOne(lenIsOne), .lenZero(lenZero),
    .recIsOne(recIsOne), .outFull(outFull), .ctl(ctl),
    .busy(busy), .done(done), .ovfErr(ovfErr), .lenErr(lenErr),
    .anyErr(anyErr), .outDis(outDis)
  );

  rec_trk_dp #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgData(cfgData),
    .inCount(inCount), .outCount(outCount), .recLeft(recLeft), .eor(eor),
    .expand(expand), .lenBad(lenBad), .lenIsOne(lenIsOne), .lenZero(lenZero),
    .recIsOne(recIsOne), .outFull(outFull)
  );

  always_comb begin
    status             = '0;
    status[ST_BUSY]    = busy;
    status[ST_DONE]    = done;
    status[ST_EXPAND]  = expand;
    status[ST_OVF]     = ovfErr;
    status[ST_LENERR]  = lenErr;
    status[ST_ANYERR]  = anyErr;
    status[ST_OUTDIS]  = outDis;
    doneIrq            = done && !doneMask;
  end

  // R6
  eor_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    eor |-> $past(inByte && !inPad));

  // R9
  ovf_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfErr) |-> (outCount == '1) && !busy);
endmodule

// File: tb/tb_rec_seg_tracker.sv
module tb_rec_seg_tracker;
  localparam int W = 8;
  localparam int B_BUSY = 0, B_DONE = 1, B_EXP = 2, B_OVF = 3,
                 B_LEN = 4, B_ANY = 5, B_DIS = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 0, start = 0, outDisMode = 0, inByte = 0, inPad = 0;
  logic outByte = 0, outPad = 0, outLast = 0, doneMask = 0;
  logic [1:0] cfgSel = 0;
  logic [W-1:0] cfgData = 0;
  logic [W-1:0] inCount, outCount, recLeft;
  logic eor, doneIrq;
  logic [6:0] status;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rec_seg_tracker #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .start(start), .outDisMode(outDisMode), .inByte(inByte), .inPad(inPad),
    .outByte(outByte), .outPad(outPad), .outLast(outLast), .doneMask(doneMask),
    .inCount(inCount), .outCount(outCount), .recLeft(recLeft), .eor(eor),
    .status(status), .doneIrq(doneIrq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input int val);
    @(negedge clk); cfgWe = 1; cfgSel = sel; cfgData = W'(val);
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic go(input logic mode);
    @(negedge clk); start = 1; outDisMode = mode;
    @(negedge clk); start = 0; outDisMode = 0;
  endtask

  task automatic inb(input logic pad);
    @(negedge clk); inByte = 1; inPad = pad;
    @(negedge clk); inByte = 0; inPad = 0;
  endtask

  task automatic outb(input logic pad, input logic last);
    @(negedge clk); outByte = 1; outPad = pad; outLast = last;
    @(negedge clk); outByte = 0; outPad = 0; outLast = 0;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) inb(0);
  endtask

  task automatic t_reset();
    check("R1 status", status, 0);
    check("R1 inCount", inCount, 0);
    check("R1 outCount", outCount, 0);
    check("R1 recLeft", recLeft, 0);
    check("R1 eor", eor, 0);
  endtask

  task automatic t_length_rules();
    cfg(0, 'h22); cfg(1, 2); go(0);
    check("R4 lenErr", status[B_LEN], 1);
    check("R4 anyErr", status[B_ANY], 1);
    check("R4 busy", status[B_BUSY], 0);
    cfg(1, 0); go(0);
    check("R3 busy", status[B_BUSY], 1);
    check("R3 lenErr cleared", status[B_LEN], 0);
    check("R3 anyErr cleared", status[B_ANY], 0);
    check("R3 zero count as one", recLeft, 1);
    feed('h22);
    check("R6 eor single", eor, 1);
    inb(0);
    check("R6 extra byte not counted", inCount, 'h22);
    outb(0, 1);
    check("R7 done", status[B_DONE], 1);
    check("R7 busy cleared", status[B_BUSY], 0);
    check("R7 doneIrq", doneIrq, 1);
    doneMask = 1; #1;
    check("R7 doneIrq masked", doneIrq, 0);
    doneMask = 0;
  endtask

  task automatic t_multi();
    cfg(0, 'h23); cfg(1, 3); go(0);
    check("R3 done cleared", status[B_DONE], 0);
    check("R3 recLeft", recLeft, 3);
    outb(0, 1);
    check("R7 early last ignored", status[B_DONE], 0);
    check("R5 out counted", outCount, 1);
    outb(1, 0);
    check("R5 out pad", outCount, 1);
    feed(34);
    check("R6 no eor early", eor, 0);
    inb(1);
    check("R5 in pad", inCount, 34);
    check("R6 pad no eor", eor, 0);
    inb(0);
    check("R6 eor rec1", eor, 1);
    check("R6 recLeft 2", recLeft, 2);
    @(negedge clk);
    check("R6 eor one cycle", eor, 0);
    cfg(0, 'h30);
    feed('h23);
    check("R2 write ignored eor", eor, 1);
    check("R2 inCount", inCount, 70);
    check("R6 recLeft 1", recLeft, 1);
    feed('h23);
    check("R6 eor last", eor, 1);
    check("R6 recLeft stays 1", recLeft, 1);
    outb(0, 1);
    check("R7 done multi", status[B_DONE], 1);
    check("R7 outCount", outCount, 2);
  endtask

  task automatic t_expand();
    cfg(0, 'h40); cfg(1, 1); go(0);
    check("R3 counters cleared", inCount + outCount, 0);
    check("R8 equal zero", status[B_EXP], 0);
    feed(2);
    outb(0, 0); outb(0, 0);
    check("R8 equal", status[B_EXP], 0);
    outb(0, 0);
    check("R8 out gt in", status[B_EXP], 1);
    feed(2);
    check("R8 back off", status[B_EXP], 0);
  endtask

  task automatic t_overflow();
    go(0);
    check("R3 start when idle only", inCount, 4);
    for (int i = 0; i < 252; i++) outb(0, 0);
    check("R9 at max", outCount, 255);
    check("R9 no ovf yet", status[B_OVF], 0);
    outb(0, 0);
    check("R9 ovf", status[B_OVF], 1);
    check("R9 anyErr", status[B_ANY], 1);
    check("R9 busy cleared", status[B_BUSY], 0);
    check("R9 saturated", outCount, 255);
    go(0);
    check("R3 ovf cleared", status[B_OVF], 0);
    check("R3 anyErr cleared", status[B_ANY], 0);
  endtask

  task automatic t_outdis();
    feed('h40);
    outb(0, 1);
    cfg(0, 'h23); cfg(1, 3); cfg(2, 2); go(1);
    check("R10 outDis set", status[B_DIS], 1);
    outb(0, 0);
    check("R10 dropped", outCount, 0);
    feed(69);
    check("R10 still disabled", status[B_DIS], 1);
    inb(0);
    check("R10 cleared", status[B_DIS], 0);
    outb(0, 0);
    check("R10 counted again", outCount, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_length_rules();
    t_multi();
    t_expand();
    t_overflow();
    t_outdis();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule